// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a serial two-wire bus slave. It gives a bus master read and write access to an internal bank of sixty-four 8-bit registers. The bus inputs are the sampled clock and data lines. The block drives the data line only through an open-drain enable: high means pull the line low. Each line passes through a small sampler that reports clock edges and detects start, repeated-start and stop conditions.

After a start, the slave compares the 7-bit device address with a parameter. A write transaction continues with a command byte. The command byte sets a 6-bit register pointer, and any further bytes are written to the bank one after another. A read transaction, whether it follows a repeated start or stands alone, streams registers out from the pointer. The pointer advances after every data byte and keeps its value across stop conditions. The pointer does not wrap: writes beyond the last location are discarded, and reads beyond it return zero.

The register bank has no reset and a registered read port, so it maps onto a block RAM. The pointer, the bit engine and the data enable are reset synchronously.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave acknowledges (data low in the ninth clock) an address byte whose upper seven bits equal SLV_ADDR. On any other address it leaves the line released, ignores all clocks until the next start, and does not acknowledge later bytes.
- R2: A command byte is always acknowledged. If its bits 7 and 6 are both zero, bits 5:0 load the pointer. Otherwise the pointer keeps its previous value.
- R3: In a write transaction, each data byte after the command is acknowledged and stored in the register the pointer selects.
- R4: After each stored byte the pointer increments by one, so consecutive bytes of one transaction fill consecutive registers.
- R5: After location 63 has been written, later data bytes of the same transaction are acknowledged but change no register (in particular, location 0 is not touched) until the next start.
- R6: After an address byte with bit 0 = 1, the slave shifts out the register at the pointer, most significant bit first, changing the data line only while the clock is low.
- R7: While the master acknowledges, successive registers follow. After a master NACK the slave releases the line for the rest of the transaction.
- R8: Once location 63 has been read in a transaction, every further byte of that transaction reads as 0x00.
- R9: A send-byte (address, command, stop) only moves the pointer. A following receive-byte (address with read bit, no command) returns the register at that pointer, because the pointer keeps its value across stop.
- R10: After reset and after every stop the data enable is off. The enable changes only one cycle after a detected clock fall, start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| sda_oe | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The assertions assume the bus lines stay stable for several system clocks between changes, and that data changes only while the bus clock is low, except at intended start and stop conditions. Otherwise the two-flop sampler could see a data change and a clock edge in the same sample and report a false condition. The bench master holds every bus phase for eight system clocks and changes data only in the low phase of the clock. It never drives a low level while expecting the slave to answer, and it ends each read with a NACK before the stop.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } smb_state_t;
endpackage

// File: rtl/smb_line_sampler.sv
module smb_line_sampler (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q1, scl_q2, sda_q1, sda_q2;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q1 <= 1'b1; scl_q2 <= 1'b1;
      sda_q1 <= 1'b1; sda_q2 <= 1'b1;
    end else begin
      scl_q1 <= scl_i; scl_q2 <= scl_q1;
      sda_q1 <= sda_i; sda_q2 <= sda_q1;
    end
  end

  assign scl_s     = scl_q1;
  assign sda_s     = sda_q1;
  assign scl_rise  = scl_q1 & ~scl_q2;
  assign scl_fall  = ~scl_q1 & scl_q2;
  assign start_evt = scl_q1 & scl_q2 & sda_q2 & ~sda_q1;
  assign stop_evt  = scl_q1 & scl_q2 & ~sda_q2 & sda_q1;
endmodule

// File: rtl/smb_reg_array.sv
module smb_reg_array #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave
  import smb_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h2C,
  parameter int         DW       = 8,
  parameter int         ADDR_W   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int              CW   = $clog2(DW + 1);
  localparam logic [CW-1:0]   BITS = CW'(DW);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  smb_state_t state, nxt;
  logic [CW-1:0]     cnt;
  logic [DW-1:0]     shreg, rd_data, tx_byte;
  logic [ADDR_W-1:0] ptr;
  logic wr_done, rd_over, m_ack, wr_en, do_load, quiet, byte_done;

  smb_line_sampler u_sampler (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_reg_array #(.DW(DW), .AW(ADDR_W)) u_bank (
    .clk(clk), .we(wr_en), .addr(ptr), .wdata(shreg), .rdata(rd_data)
  );

  always_comb begin
    quiet     = ~start_evt & ~stop_evt;
    byte_done = (cnt == BITS);
    wr_en     = quiet & (state == ST_WDATA) & scl_fall & byte_done & ~wr_done;
    do_load   = quiet & scl_fall &
                (((state == ST_ACK) & (nxt == ST_RDATA)) | ((state == ST_RACK) & m_ack));
    tx_byte   = rd_over ? '0 : rd_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; shreg <= '0;
      sda_oe <= 1'b0; ptr <= '0; wr_done <= 1'b0; rd_over <= 1'b0; m_ack <= 1'b0;
    end else if (start_evt) begin
      state <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0;
      wr_done <= 1'b0; rd_over <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE; sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_CMD, ST_WDATA: begin
          if (scl_rise && !byte_done) begin
            shreg <= {shreg[DW-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (scl_fall && byte_done) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[DW-1:1] == SLV_ADDR) begin
                sda_oe <= 1'b1; state <= ST_ACK;
                nxt    <= shreg[0] ? ST_RDATA : ST_CMD;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_CMD) begin
              sda_oe <= 1'b1; state <= ST_ACK; nxt <= ST_WDATA;
              if (shreg[DW-1:ADDR_W] == '0) ptr <= shreg[ADDR_W-1:0];
            end else begin
              sda_oe <= 1'b1; state <= ST_ACK; nxt <= ST_WDATA;
              if (!wr_done) begin
                if (ptr == LAST) wr_done <= 1'b1;
                else             ptr     <= ptr + 1'b1;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall && nxt != ST_RDATA) begin
            sda_oe <= 1'b0; cnt <= '0; state <= nxt;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (byte_done) begin
              sda_oe <= 1'b0; state <= ST_RACK;
            end else begin
              shreg  <= {shreg[DW-2:0], 1'b0};
              sda_oe <= ~shreg[DW-2];
              cnt    <= cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) m_ack <= ~sda_s;
          else if (scl_fall && !m_ack) state <= ST_IDLE;
        end
        default: ;
      endcase
      if (do_load) begin
        state  <= ST_RDATA;
        shreg  <= tx_byte;
        sda_oe <= ~tx_byte[DW-1];
        cnt    <= CW'(1);
        if (ptr == LAST) rd_over <= 1'b1;
        else             ptr     <= ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/smb_regbank_checker.sv
module smb_regbank_checker
  import smb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_fall,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              wr_en,
  input logic              wr_done,
  input logic              rd_over,
  input logic [ADDR_W-1:0] ptr,
  input smb_state_t        state
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  AST_OE_OFF_AFTER_STOP: assert property (@(posedge clk) disable iff (rst) stop_evt |=> !sda_oe); // R10
  AST_OE_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt))); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE) |-> !sda_oe); // R1
  AST_PTR_ON_FALL: assert property (@(posedge clk) disable iff (rst) (ptr != $past(ptr)) |-> $past(scl_fall)); // R4
  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((ptr == $past(ptr) + 1'b1) || wr_done)); // R4
  AST_WR_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_done && !start_evt) |=> wr_done); // R5
  AST_RDOVER_AT_END: assert property (@(posedge clk) disable iff (rst) rd_over |-> (ptr == LAST)); // R8
endmodule

bind smb_regbank_slave smb_regbank_checker #(.ADDR_W(ADDR_W)) u_checker (
  .clk(clk), .rst(rst), .sda_oe(sda_oe), .scl_fall(scl_fall), .start_evt(start_evt),
  .stop_evt(stop_evt), .wr_en(wr_en), .wr_done(wr_done), .rd_over(rd_over),
  .ptr(ptr), .state(state)
);

// File: tb/test_smb_regbank_slave.sv
module test_smb_regbank_slave;
  localparam int         Q   = 8;
  localparam logic [6:0] DEV = 7'h2C;
  localparam int         NV  = 8;
  localparam logic [13:0] VEC [NV] = '{
    {6'd0, 8'hA5}, {6'd5, 8'h3C}, {6'd10, 8'h81}, {6'd11, 8'h7E},
    {6'd12, 8'h00}, {6'd13, 8'hFF}, {6'd33, 8'h5A}, {6'd47, 8'hC3}
  };

  logic clk = 1'b0, rst = 1'b1, m_scl = 1'b1, m_sda_low = 1'b0;
  logic sda_oe, sda_line;
  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  assign sda_line = ~(m_sda_low | sda_oe);
  always #2 clk = ~clk;

  smb_regbank_slave #(.SLV_ADDR(DEV)) i_smb_regbank_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic r);
    m_sda_low = ~b; wq();
    m_scl = 1'b1; wq();
    r = sda_line; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_start();
    m_sda_low = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    m_sda_low = 1'b1; wq();
    m_scl = 1'b1; wq();
    m_sda_low = 1'b0; wq();
  endtask

  task automatic tx_byte(input logic [7:0] d, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
    bit_xfer(1'b1, r);
    ack = ~r;
  endtask

  task automatic rx_byte(input logic mack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, r);
      d[i] = r;
    end
    bit_xfer(~mack, r);
  endtask

  task automatic send_cmd(input logic [7:0] c, input string req);
    logic a;
    do_start();
    tx_byte({DEV, 1'b0}, a); chk("R1 address ack", int'(a), 1);
    tx_byte(c, a);           chk(req, int'(a), 1);
    do_stop();
  endtask

  task automatic recv_one(output logic [7:0] d);
    logic a;
    do_start();
    tx_byte({DEV, 1'b1}, a); chk("R1 read address ack", int'(a), 1);
    rx_byte(1'b0, d);
    do_stop();
  endtask

  task automatic reg_write(input logic [5:0] ra, input logic [7:0] d);
    logic a;
    do_start();
    tx_byte({DEV, 1'b0}, a); chk("R1 address ack", int'(a), 1);
    tx_byte({2'b00, ra}, a);
    tx_byte(d, a);           chk("R3 data ack", int'(a), 1);
    do_stop();
  endtask

  task automatic reg_read(input logic [5:0] ra, output logic [7:0] d);
    logic a;
    do_start();
    tx_byte({DEV, 1'b0}, a);
    tx_byte({2'b00, ra}, a);
    do_start();
    tx_byte({DEV, 1'b1}, a);
    rx_byte(1'b0, d);
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic a, r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 released after reset", int'(sda_line), 1);

    // R3/R6: table of register values written by write-byte, read back by read-byte
    for (int i = 0; i < NV; i++) begin
      reg_write(VEC[i][13:8], VEC[i][7:0]);
      reg_read(VEC[i][13:8], d);
      chk("R6 read-byte value", int'(d), int'(VEC[i][7:0]));
    end

    // R1: wrong address is not acknowledged, later byte ignored
    do_start();
    tx_byte({7'h13, 1'b0}, a); chk("R1 foreign address nack", int'(a), 0);
    tx_byte(8'h00, a);         chk("R1 ignored until start", int'(a), 0);
    do_stop();
    chk("R10 released after stop", int'(sda_line), 1);

    // R4/R5: multi-byte write from 62 runs off the end
    do_start();
    tx_byte({DEV, 1'b0}, a);
    tx_byte(8'd62, a);
    tx_byte(8'h11, a); chk("R3 ack 62", int'(a), 1);
    tx_byte(8'h22, a); chk("R4 ack 63", int'(a), 1);
    tx_byte(8'h33, a); chk("R5 ack past end", int'(a), 1);
    do_stop();
    reg_read(6'd62, d); chk("R3 reg62", int'(d), 'h11);
    reg_read(6'd63, d); chk("R4 reg63 next", int'(d), 'h22);
    reg_read(6'd0, d);  chk("R5 reg0 untouched", int'(d), 'hA5);

    // R7: multi-byte read of consecutive registers, then release after NACK
    do_start();
    tx_byte({DEV, 1'b0}, a);
    tx_byte(8'd10, a);
    do_start();
    tx_byte({DEV, 1'b1}, a);
    rx_byte(1'b1, d); chk("R7 first reg10", int'(d), 'h81);
    rx_byte(1'b1, d); chk("R7 second reg11", int'(d), 'h7E);
    rx_byte(1'b0, d); chk("R7 third reg12", int'(d), 'h00);
    bit_xfer(1'b1, r); chk("R7 released after nack", int'(r), 1);
    do_stop();

    // R8: reading past location 63 yields zero
    do_start();
    tx_byte({DEV, 1'b0}, a);
    tx_byte(8'd62, a);
    do_start();
    tx_byte({DEV, 1'b1}, a);
    rx_byte(1'b1, d); chk("R8 reg62", int'(d), 'h11);
    rx_byte(1'b1, d); chk("R8 reg63", int'(d), 'h22);
    rx_byte(1'b1, d); chk("R8 zero after end", int'(d), 'h00);
    rx_byte(1'b0, d); chk("R8 zero again", int'(d), 'h00);
    do_stop();

    // R9: send-byte sets pointer, receive-byte reads it across stop
    send_cmd(8'd13, "R9 command ack");
    recv_one(d); chk("R9 receive-byte reg13", int'(d), 'hFF);
    send_cmd(8'd33, "R9 command ack");
    recv_one(d); chk("R9 receive-byte reg33", int'(d), 'h5A);

    // R2: command with top bits set is acked but leaves pointer alone
    send_cmd(8'd5, "R2 command ack");
    send_cmd(8'h4C, "R2 bad command ack bit6");
    send_cmd(8'h8C, "R2 bad command ack bit7");
    recv_one(d); chk("R2 pointer unchanged", int'(d), 'h3C);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule